// File: doc/BRIEF.md
# Priority Pin Crossbar Assigner

This block places the enabled on-chip peripheral signals onto an 8-pin port. It walks through the signals in a fixed priority order. Each enabled signal takes the lowest pin that is free and not masked off. The UART transmit and receive lines are an exception: whenever the UART is enabled, they take pins 4 and 5. The two-wire bus data and clock lines are placed as a pair or not at all. Any pin left unclaimed, including every skipped pin, is driven from the general-purpose I/O registers.

The placement is computed combinationally from the enable and skip inputs and captured in a per-pin owner register. That register changes one clock after the configuration changes. Pin drive, pin output enable and the input levels routed back to the peripherals are derived from the registered owner map without further delay. If an enabled signal finds no pin, it is dropped and a sticky-free overflow flag is raised for as long as that configuration holds.

Top module: `pin_xbar`

## Requirements
- R1: While reset is asserted, every owner code is 0, `overflow` is 0, and every pin follows `gpio_out`/`gpio_oe`.
- R2: When `func_en[0]` (UART) is set, pin 4 gets owner code 1 (transmit) and pin 5 gets owner code 2 (receive), whatever the skip mask and the other enables are.
- R3: When `func_en[1]` (two-wire bus) is set, data (code 3) and clock (code 4) take the two lowest free non-skipped pins, with data on the lower pin. If fewer than two such pins remain, neither is placed and `overflow` is 1.
- R4: A set bit `skip_mask[p]` for p in 0..6 keeps the walk off pin p. `skip_mask[7]` has no effect.
- R5: The remaining signals are placed after the UART and the bus, in this order with these codes and enable bits: comparator 5 (`func_en[2]`), comparator async 6 (`[3]`), system clock 7 (`[4]`), capture outputs 0..2 codes 8..10 (`[5]`..`[7]`), counter clock input 11 (`[8]`), timer 0 input 12 (`[9]`), timer 1 input 13 (`[10]`). Each takes the lowest free pin, and no code appears on more than one pin.
- R6: An enabled signal that finds no free pin is dropped (its code appears on no pin) and `overflow` is 1. Otherwise `overflow` is 0.
- R7: A pin with owner code 0 drives `pin_out[p]=gpio_out[p]` and `pin_oe[p]=gpio_oe[p]`.
- R8: A pin owned by code c drives `pin_out=sig_o[c]`. Its `pin_oe` is `sig_oe[c]`, except for the input-type codes 2, 11, 12 and 13, where `pin_oe` is 0.
- R9: `sig_i[c]` equals `pin_in` of the pin owned by code c. If no pin holds code c, `sig_i[c]` is 1.
- R10: `pin_owner` (4 bits per pin, pin p at bits 4p+3:4p) and `overflow` reflect the `func_en`/`skip_mask` values present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_en | input | 11 | Peripheral enable bits (see R2, R3, R5) |
| skip_mask | input | 8 | Pins removed from the walk; bit 7 ignored |
| sig_o | input | 16 | Peripheral output value indexed by owner code |
| sig_oe | input | 16 | Peripheral output enable indexed by owner code |
| gpio_out | input | 8 | General-purpose output values |
| gpio_oe | input | 8 | General-purpose output enables |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |
| pin_owner | output | 32 | Owner code per pin, 4 bits each |
| sig_i | output | 16 | Pin level routed to each code, 1 if unplaced |
| overflow | output | 1 | An enabled signal was dropped |

## Verification
The owner map and the overflow flag are due one rising edge after a configuration is applied. The driver applies each configuration at a falling edge and queues the expected map. The monitor pops that entry shortly after the next rising edge, so every map comparison lands in the first cycle in which it is valid. Pin drive, output enable and routed inputs have no added latency relative to the owner register. They are sampled at a falling edge after the map has settled, while the peripheral and GPIO stimulus is held steady.

// File: rtl/pin_xbar.sv
module pin_xbar (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] func_en,
  input  logic [7:0]  skip_mask,
  input  logic [15:0] sig_o,
  input  logic [15:0] sig_oe,
  input  logic [7:0]  gpio_out,
  input  logic [7:0]  gpio_oe,
  input  logic [7:0]  pin_in,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe,
  output logic [31:0] pin_owner,
  output logic [15:0] sig_i,
  output logic        overflow
);
  localparam int NPIN = 8;
  localparam int CW = 4;
  localparam int TX_PIN = 4;
  localparam int RX_PIN = 5;
  localparam int LAST_CODE = 13;
  localparam logic [15:0] IN_CODES = 16'h3804;

  logic [NPIN-1:0]         taken;
  logic [NPIN-1:0][CW-1:0] own_d, own_q;
  logic                    ovf_d, ovf_q;
  logic [2:0]              lo, hi;
  logic                    f_lo, f_hi;

  always_comb begin
    taken = {1'b0, skip_mask[NPIN-2:0]};
    own_d = '0;
    ovf_d = 1'b0;
    lo = '0; hi = '0; f_lo = 1'b0; f_hi = 1'b0;
    if (func_en[0]) begin
      taken[TX_PIN] = 1'b1;
      taken[RX_PIN] = 1'b1;
      own_d[TX_PIN] = CW'(1);
      own_d[RX_PIN] = CW'(2);
    end
    if (func_en[1]) begin
      for (int p = 0; p < NPIN; p++)
        if (!taken[p]) begin
          if (!f_lo) begin f_lo = 1'b1; lo = 3'(p); end
          else if (!f_hi) begin f_hi = 1'b1; hi = 3'(p); end
        end
      if (f_hi) begin
        own_d[lo] = CW'(3);
        own_d[hi] = CW'(4);
        taken[lo] = 1'b1;
        taken[hi] = 1'b1;
      end else ovf_d = 1'b1;
    end
    for (int c = 5; c <= LAST_CODE; c++)
      if (func_en[c-3]) begin
        f_lo = 1'b0;
        lo = '0;
        for (int p = 0; p < NPIN; p++)
          if (!taken[p] && !f_lo) begin f_lo = 1'b1; lo = 3'(p); end
        if (f_lo) begin
          own_d[lo] = CW'(c);
          taken[lo] = 1'b1;
        end else ovf_d = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      own_q <= own_d;
      ovf_q <= ovf_d;
    end

  assign pin_owner = own_q;
  assign overflow  = ovf_q;

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      if (own_q[p] == '0) begin
        pin_out[p] = gpio_out[p];
        pin_oe[p]  = gpio_oe[p];
      end else begin
        pin_out[p] = sig_o[own_q[p]];
        pin_oe[p]  = sig_oe[own_q[p]] & ~IN_CODES[own_q[p]];
      end
    end
  end

  always_comb begin
    sig_i = '1;
    for (int p = 0; p < NPIN; p++)
      if (own_q[p] != '0) sig_i[own_q[p]] = pin_in[p];
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] func_en,
  input logic [7:0]  skip_mask,
  input logic [15:0] sig_o,
  input logic [15:0] sig_oe,
  input logic [7:0]  gpio_out,
  input logic [7:0]  gpio_oe,
  input logic [7:0]  pin_in,
  input logic [7:0]  pin_out,
  input logic [7:0]  pin_oe,
  input logic [31:0] pin_owner,
  input logic [15:0] sig_i,
  input logic        overflow
);
  logic [15:0][7:0] hit;
  always_comb
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 8; p++)
        hit[c][p] = (pin_owner[4*p +: 4] == 4'(c));

  // R2
  uart_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(func_en[0]) |-> pin_owner[19:16] == 4'd1 && pin_owner[23:20] == 4'd2);

  genvar p, c;
  generate
    for (p = 0; p < 7; p++) begin : g_skip
      // R4
      skip_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(skip_mask[p]) && !($past(func_en[0]) && (p == 4 || p == 5))
        |-> pin_owner[4*p +: 4] == 4'd0);
    end
    for (p = 0; p < 8; p++) begin : g_pin
      // R7
      gpio_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_owner[4*p +: 4] == 4'd0 |-> pin_out[p] == gpio_out[p] && pin_oe[p] == gpio_oe[p]);
      // R8
      in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_owner[4*p +: 4] == 4'd2 || pin_owner[4*p +: 4] >= 4'd11) |-> !pin_oe[p]);
    end
    for (c = 1; c < 14; c++) begin : g_code
      // R5
      single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit[c]) <= 1);
      // R9
      idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[c] == 8'd0 |-> sig_i[c]);
    end
  endgenerate

  // R3
  pair_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit[3]) == $countones(hit[4]));
endmodule

bind pin_xbar pin_xbar_chk u_chk (.*);

// File: tb/tb_pin_xbar.sv
module tb_pin_xbar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] func_en = '0;
  logic [7:0]  skip_mask = '0;
  logic [15:0] sig_o = '0, sig_oe = '0;
  logic [7:0]  gpio_out = '0, gpio_oe = '0, pin_in = '0;
  logic [7:0]  pin_out, pin_oe;
  logic [31:0] pin_owner;
  logic [15:0] sig_i;
  logic        overflow;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] own;
    logic        ovf;
    string       tag;
  } exp_t;
  exp_t sb[$];

  pin_xbar dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_walk(input logic [10:0] en, input logic [7:0] sk,
                                   output logic [31:0] own, output logic ovf);
    bit busy [8];
    int pa, pb;
    own = '0;
    ovf = 1'b0;
    for (int i = 0; i < 7; i++) busy[i] = sk[i];
    busy[7] = 1'b0;
    if (en[0]) begin
      own[19:16] = 4'd1; own[23:20] = 4'd2;
      busy[4] = 1'b1; busy[5] = 1'b1;
    end
    if (en[1]) begin
      pa = -1; pb = -1;
      for (int i = 0; i < 8; i++)
        if (!busy[i]) begin
          if (pa < 0) pa = i;
          else if (pb < 0) pb = i;
        end
      if (pb >= 0) begin
        own[4*pa +: 4] = 4'd3; own[4*pb +: 4] = 4'd4;
        busy[pa] = 1'b1; busy[pb] = 1'b1;
      end else ovf = 1'b1;
    end
    for (int k = 2; k <= 10; k++) begin
      if (!en[k]) continue;
      pa = -1;
      for (int i = 7; i >= 0; i--) if (!busy[i]) pa = i;
      if (pa >= 0) begin
        own[4*pa +: 4] = 4'(k + 3);
        busy[pa] = 1'b1;
      end else ovf = 1'b1;
    end
  endfunction

  task automatic apply(logic [10:0] en, logic [7:0] sk, string tag);
    exp_t e;
    @(negedge clk);
    func_en = en;
    skip_mask = sk;
    ref_walk(en, sk, e.own, e.ovf);
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb.size() > 0) begin
        e = sb.pop_front();
        chk({e.tag, " R10 owner"}, 64'(pin_owner), 64'(e.own));
        chk({e.tag, " R6 overflow"}, 64'(overflow), 64'(e.ovf));
      end
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    gpio_out = 8'hA5; gpio_oe = 8'h3C;
    func_en = 11'h7FF;
    repeat (3) @(negedge clk);
    chk("R1 owner in reset", 64'(pin_owner), 64'd0);
    chk("R1 overflow in reset", 64'(overflow), 64'd0);
    chk("R1 pins follow gpio", 64'({pin_out, pin_oe}), 64'({8'hA5, 8'h3C}));
    func_en = '0;
    rst_n = 1'b1;

    // R2 R3 R4: uart + bus + sysclk, pins 0 and 3 skipped
    apply(11'b000_0001_0011, 8'h09, "R2 R3 R4 example");
    drain();
    chk("R3 data lowest free", 64'(pin_owner[7:4]), 64'd3);
    chk("R3 clock next free", 64'(pin_owner[11:8]), 64'd4);
    chk("R2 tx on pin4", 64'(pin_owner[19:16]), 64'd1);
    chk("R2 rx on pin5", 64'(pin_owner[23:20]), 64'd2);
    chk("R5 sysclk pin6", 64'(pin_owner[27:24]), 64'd7);

    // R3: one free pin left, pair dropped, comparator takes pin 7
    apply(11'b000_0000_0111, 8'h4F, "R3 pair short");
    drain();
    chk("R3 pair dropped", 64'(pin_owner), 64'(32'h5021_0000));
    chk("R6 overflow on pair", 64'(overflow), 64'd1);

    // R4: bit 7 of skip has no effect
    apply(11'b000_0000_0100, 8'hFF, "R4 skip bit7");
    drain();
    chk("R4 pin7 usable", 64'(pin_owner), 64'(32'h5000_0000));

    // R5 R6: everything but uart, no skip -> overflow
    apply(11'h7FE, 8'h00, "R5 R6 all");
    drain();
    chk("R5 order", 64'(pin_owner), 64'(32'hA987_6543));
    chk("R6 overflow all", 64'(overflow), 64'd1);

    // R7 R8 R9 routing
    apply(11'b010_0000_0001, 8'h00, "R8 R9 routing");
    drain();
    sig_o = 16'h0002; sig_oe = 16'hFFFF; pin_in = 8'b1101_1110;
    gpio_out = 8'h00; gpio_oe = 8'hFF;
    #1;
    chk("R8 tx drive", 64'({pin_out[4], pin_oe[4]}), 64'(2'b11));
    chk("R8 rx not driven", 64'(pin_oe[5]), 64'd0);
    chk("R8 timer0 not driven", 64'(pin_oe[0]), 64'd0);
    chk("R9 rx routed", 64'(sig_i[2]), 64'(pin_in[5]));
    chk("R9 timer0 routed", 64'(sig_i[12]), 64'd0);
    chk("R9 unplaced high", 64'(sig_i[11]), 64'd1);
    chk("R7 gpio pin1", 64'({pin_out[1], pin_oe[1]}), 64'(2'b01));

    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[10:0], lfsr[23:16], "R2 R3 R4 R5 R6 sweep");
    end
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule